// File: doc/BRIEF.md
# Line Return Buffer for Two Pipelines

This block keeps one returned cache line for each of two pipelines: pipe 0 serves loads and stores, and pipe 1 serves loads only. A fill writes a line into one pipe's slot. The slot keeps the line data, the fill address with its offset bits cleared, and a request number. A separate port can rewrite that request number without touching the data. The request number tells apart the access that owns the line from a later access that reaches the same address.

The pipeline asks whether a word is present by giving a pipe, an address and a request number. The answer comes back combinationally as a hit flag and the 32-bit word at that address inside the line. A store or preload to a buffered line must remove the stale copy from both pipes, so the block takes an invalidate by address that checks both slots. It also takes an invalidate-all strobe. Cache lookup and memory traffic are handled elsewhere.

Fills arrive on a valid/ready port. The block holds `fill_ready` high at all times and never pushes back, so a fill is taken on every cycle in which `fill_valid` is high. The request-number write, the invalidates and the query are plain single-cycle control pins.

Top module: `line_return_buffer`

## Requirements
- R1: After reset, neither pipe reports a hit for any address or request number.
- R2: A fill (`fill_valid` high, `fill_ready` always high) stores the line in slot `fill_pipe`, stores `fill_addr` with its low log2(LINE_BYTES) bits cleared, stores `fill_reqno`, and marks the slot valid from the next cycle.
- R3: A query hits only if the selected slot is valid, its request number equals `q_reqno`, and base <= `q_addr` < base + LINE_BYTES.
- R4: `q_word` is bits [32k+31:32k] of the stored line, where k = `q_addr`[log2(LINE_BYTES)-1:2].
- R5: A request-number write (`rn_valid`) replaces the stored request number of slot `rn_pipe` and leaves its data, address and valid flag unchanged. If a fill targets the same pipe in the same cycle, the written request number wins.
- R6: An invalidate by address clears every slot whose base equals `inv_addr` with its offset bits cleared, in both pipes. Slots holding other lines keep their contents.
- R7: `inv_all` clears the valid flag of both slots.
- R8: When a fill and an invalidate (by address or all) hit the same pipe in the same cycle, the fill takes effect. The other pipe is still invalidated.
- R9: A fill or request-number write to one pipe leaves the other pipe's slot unchanged.
- R10: The query path is combinational. A query sees the state stored at the last clock edge, so a fill can be seen on the cycle after it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | Fill strobe |
| fill_ready | output | 1 | Fill accept, always high |
| fill_pipe | input | PIPE_W | Slot to fill (0 load/store, 1 load) |
| fill_addr | input | ADDR_W | Address of the fill |
| fill_reqno | input | REQNO_W | Request number stored with the fill |
| fill_line | input | LINE_BYTES*8 | Line data, word 0 in the low bits |
| rn_valid | input | 1 | Request-number write strobe |
| rn_pipe | input | PIPE_W | Slot whose request number is written |
| rn_reqno | input | REQNO_W | New request number |
| inv_valid | input | 1 | Invalidate-by-address strobe |
| inv_addr | input | ADDR_W | Address whose line is invalidated |
| inv_all | input | 1 | Invalidate both slots |
| q_pipe | input | PIPE_W | Slot to query |
| q_addr | input | ADDR_W | Query address |
| q_reqno | input | REQNO_W | Query request number |
| q_hit | output | 1 | Query hit |
| q_word | output | WORD_W | Word selected by the query address |

## Verification
The assertions assume that the pipe selects always name an existing slot and that every input is at a known level once reset is released. They also assume strobes are sampled only at clock edges. The properties that check an invalidate leave out any cycle in which a fill targets the same pipe, because R8 lets the fill win there. The stimulus holds every strobe low during reset, raises each strobe for exactly one cycle, and drops it again just after the edge. It uses only the two legal pipe values, and it changes query inputs only while no strobe is pending.

// File: rtl/lrb_pkg.sv
package lrb_pkg;
  localparam int unsigned LRB_ADDR_W     = 32;
  localparam int unsigned LRB_LINE_BYTES = 32;
  localparam int unsigned LRB_REQNO_W    = 8;
  localparam int unsigned LRB_WORD_W     = 32;
  localparam int unsigned LRB_NPIPE      = 2;

  typedef enum logic [0:0] {
    PIPE_LS = 1'b0,
    PIPE_LD = 1'b1
  } pipe_e;
endpackage

// File: rtl/lrb_slot.sv
module lrb_slot #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 32,
  parameter int unsigned REQNO_W    = 8,
  parameter int unsigned LINE_BITS  = LINE_BYTES * 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fill_en,
  input  logic [ADDR_W-1:0]    fill_base,
  input  logic [LINE_BITS-1:0] fill_line,
  input  logic [REQNO_W-1:0]   fill_reqno,
  input  logic                 rn_en,
  input  logic [REQNO_W-1:0]   rn_val,
  input  logic                 inv_en,
  input  logic [ADDR_W-1:0]    inv_addr,
  input  logic                 inv_all,
  output logic                 vld,
  output logic [ADDR_W-1:0]    base,
  output logic [REQNO_W-1:0]   reqno,
  output logic [LINE_BITS-1:0] line
);
  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(LINE_BYTES - 1);

  logic inv_match;
  logic kill;

  assign inv_match = inv_en && vld && ((inv_addr & ~OFS_MASK) == base);
  assign kill      = inv_all || inv_match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld   <= 1'b0;
      base  <= '0;
      line  <= '0;
    end else if (fill_en) begin
      vld   <= 1'b1;
      base  <= fill_base;
      line  <= fill_line;
    end else if (kill) begin
      vld   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reqno <= '0;
    end else if (rn_en) begin
      reqno <= rn_val;
    end else if (fill_en) begin
      reqno <= fill_reqno;
    end
  end
endmodule

// File: rtl/lrb_probe.sv
module lrb_probe #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 32,
  parameter int unsigned REQNO_W    = 8,
  parameter int unsigned WORD_W     = 32,
  parameter int unsigned LINE_BITS  = LINE_BYTES * 8
) (
  input  logic                 vld,
  input  logic [ADDR_W-1:0]    base,
  input  logic [REQNO_W-1:0]   reqno,
  input  logic [LINE_BITS-1:0] line,
  input  logic [ADDR_W-1:0]    q_addr,
  input  logic [REQNO_W-1:0]   q_reqno,
  output logic                 hit,
  output logic [WORD_W-1:0]    word
);
  localparam int unsigned OFS_W  = $clog2(LINE_BYTES);
  localparam int unsigned WB_W   = $clog2(WORD_W / 8);
  localparam int unsigned NWORDS = LINE_BITS / WORD_W;
  localparam int unsigned WIDX_W = OFS_W - WB_W;

  logic [ADDR_W:0]     addr_x;
  logic [ADDR_W:0]     lo_x;
  logic [ADDR_W:0]     hi_x;
  logic                in_line;
  logic [WIDX_W-1:0]   widx;
  logic [WORD_W-1:0]   words [NWORDS];

  assign addr_x  = {1'b0, q_addr};
  assign lo_x    = {1'b0, base};
  assign hi_x    = lo_x + (ADDR_W + 1)'(LINE_BYTES);
  assign in_line = (addr_x >= lo_x) && (addr_x < hi_x);
  assign hit     = vld && (reqno == q_reqno) && in_line;

  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    assign words[k] = line[k*WORD_W +: WORD_W];
  end

  assign widx = q_addr[OFS_W-1:WB_W];
  assign word = words[widx];
endmodule

// File: rtl/line_return_buffer.sv
module line_return_buffer
  import lrb_pkg::*;
#(
  parameter int unsigned ADDR_W     = LRB_ADDR_W,
  parameter int unsigned LINE_BYTES = LRB_LINE_BYTES,
  parameter int unsigned REQNO_W    = LRB_REQNO_W,
  parameter int unsigned WORD_W     = LRB_WORD_W,
  parameter int unsigned NPIPE      = LRB_NPIPE,
  parameter int unsigned PIPE_W     = (NPIPE > 1) ? $clog2(NPIPE) : 1,
  parameter int unsigned LINE_BITS  = LINE_BYTES * 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fill_valid,
  output logic                 fill_ready,
  input  logic [PIPE_W-1:0]    fill_pipe,
  input  logic [ADDR_W-1:0]    fill_addr,
  input  logic [REQNO_W-1:0]   fill_reqno,
  input  logic [LINE_BITS-1:0] fill_line,
  input  logic                 rn_valid,
  input  logic [PIPE_W-1:0]    rn_pipe,
  input  logic [REQNO_W-1:0]   rn_reqno,
  input  logic                 inv_valid,
  input  logic [ADDR_W-1:0]    inv_addr,
  input  logic                 inv_all,
  input  logic [PIPE_W-1:0]    q_pipe,
  input  logic [ADDR_W-1:0]    q_addr,
  input  logic [REQNO_W-1:0]   q_reqno,
  output logic                 q_hit,
  output logic [WORD_W-1:0]    q_word
);
  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(LINE_BYTES - 1);

  logic [ADDR_W-1:0]                fill_base;
  logic [NPIPE-1:0]                 slot_vld;
  logic [NPIPE-1:0][ADDR_W-1:0]     slot_base;
  logic [NPIPE-1:0][REQNO_W-1:0]    slot_rn;
  logic [LINE_BITS-1:0]             slot_line [NPIPE];
  logic [NPIPE-1:0]                 hit_v;
  logic [WORD_W-1:0]                word_v [NPIPE];

  assign fill_ready = 1'b1;
  assign fill_base  = fill_addr & ~OFS_MASK;

  for (genvar p = 0; p < NPIPE; p++) begin : g_pipe
    logic fill_here;
    logic rn_here;

    assign fill_here = fill_valid && fill_ready && (fill_pipe == PIPE_W'(p));
    assign rn_here   = rn_valid && (rn_pipe == PIPE_W'(p));

    lrb_slot #(
      .ADDR_W    (ADDR_W),
      .LINE_BYTES(LINE_BYTES),
      .REQNO_W   (REQNO_W),
      .LINE_BITS (LINE_BITS)
    ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .fill_en   (fill_here),
      .fill_base (fill_base),
      .fill_line (fill_line),
      .fill_reqno(fill_reqno),
      .rn_en     (rn_here),
      .rn_val    (rn_reqno),
      .inv_en    (inv_valid),
      .inv_addr  (inv_addr),
      .inv_all   (inv_all),
      .vld       (slot_vld[p]),
      .base      (slot_base[p]),
      .reqno     (slot_rn[p]),
      .line      (slot_line[p])
    );

    lrb_probe #(
      .ADDR_W    (ADDR_W),
      .LINE_BYTES(LINE_BYTES),
      .REQNO_W   (REQNO_W),
      .WORD_W    (WORD_W),
      .LINE_BITS (LINE_BITS)
    ) u_probe (
      .vld    (slot_vld[p]),
      .base   (slot_base[p]),
      .reqno  (slot_rn[p]),
      .line   (slot_line[p]),
      .q_addr (q_addr),
      .q_reqno(q_reqno),
      .hit    (hit_v[p]),
      .word   (word_v[p])
    );
  end

  assign q_hit  = hit_v[q_pipe];
  assign q_word = word_v[q_pipe];
endmodule

// File: rtl/lrb_checker.sv
module lrb_checker #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LINE_BYTES = 32,
  parameter int unsigned REQNO_W    = 8,
  parameter int unsigned NPIPE      = 2,
  parameter int unsigned PIPE_W     = 1
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             fill_valid,
  input logic [PIPE_W-1:0]                fill_pipe,
  input logic                             rn_valid,
  input logic [PIPE_W-1:0]                rn_pipe,
  input logic [REQNO_W-1:0]               rn_reqno,
  input logic                             inv_valid,
  input logic [ADDR_W-1:0]                inv_addr,
  input logic                             inv_all,
  input logic [PIPE_W-1:0]                q_pipe,
  input logic [ADDR_W-1:0]                q_addr,
  input logic [REQNO_W-1:0]               q_reqno,
  input logic                             q_hit,
  input logic [NPIPE-1:0]                 slot_vld,
  input logic [NPIPE-1:0][ADDR_W-1:0]     slot_base,
  input logic [NPIPE-1:0][REQNO_W-1:0]    slot_rn
);
  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(LINE_BYTES - 1);

  p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (slot_vld == '0));

  p_fill_sets_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> slot_vld[$past(fill_pipe)]);

  p_fill_base_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> ((slot_base[$past(fill_pipe)] & OFS_MASK) == '0));

  p_hit_needs_reqno_r3: assert property (@(posedge clk) disable iff (!rst_n)
    q_hit |-> (slot_vld[q_pipe] && (slot_rn[q_pipe] == q_reqno)));

  p_hit_inside_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    q_hit |-> ((q_addr & ~OFS_MASK) == slot_base[q_pipe]));

  p_reqno_written_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rn_valid |=> (slot_rn[$past(rn_pipe)] == $past(rn_reqno)));

  p_clear_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_all && !fill_valid) |=> (slot_vld == '0));

  p_fill_beats_inv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && (inv_valid || inv_all)) |=> slot_vld[$past(fill_pipe)]);

  for (genvar p = 0; p < NPIPE; p++) begin : g_inv
    p_line_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_valid && !(fill_valid && (fill_pipe == PIPE_W'(p))))
      |=> !(slot_vld[p] && (slot_base[p] == $past(inv_addr & ~OFS_MASK))));
  end
endmodule

bind line_return_buffer lrb_checker #(
  .ADDR_W    (ADDR_W),
  .LINE_BYTES(LINE_BYTES),
  .REQNO_W   (REQNO_W),
  .NPIPE     (NPIPE),
  .PIPE_W    (PIPE_W)
) u_lrb_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fill_valid(fill_valid),
  .fill_pipe (fill_pipe),
  .rn_valid  (rn_valid),
  .rn_pipe   (rn_pipe),
  .rn_reqno  (rn_reqno),
  .inv_valid (inv_valid),
  .inv_addr  (inv_addr),
  .inv_all   (inv_all),
  .q_pipe    (q_pipe),
  .q_addr    (q_addr),
  .q_reqno   (q_reqno),
  .q_hit     (q_hit),
  .slot_vld  (slot_vld),
  .slot_base (slot_base),
  .slot_rn   (slot_rn)
);

// File: tb/line_return_buffer_tb_top.sv
`timescale 1ns/1ps
module line_return_buffer_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         fill_valid, fill_ready;
  logic [0:0]   fill_pipe;
  logic [31:0]  fill_addr;
  logic [7:0]   fill_reqno;
  logic [255:0] fill_line;
  logic         rn_valid;
  logic [0:0]   rn_pipe;
  logic [7:0]   rn_reqno;
  logic         inv_valid;
  logic [31:0]  inv_addr;
  logic         inv_all;
  logic [0:0]   q_pipe;
  logic [31:0]  q_addr;
  logic [7:0]   q_reqno;
  logic         q_hit;
  logic [31:0]  q_word;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  line_return_buffer dut_i (
    .clk(clk), .rst_n(rst_n),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_pipe(fill_pipe),
    .fill_addr(fill_addr), .fill_reqno(fill_reqno), .fill_line(fill_line),
    .rn_valid(rn_valid), .rn_pipe(rn_pipe), .rn_reqno(rn_reqno),
    .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_all(inv_all),
    .q_pipe(q_pipe), .q_addr(q_addr), .q_reqno(q_reqno),
    .q_hit(q_hit), .q_word(q_word)
  );

  function automatic logic [31:0] exp_word(input logic [31:0] seed, input logic [31:0] addr);
    return seed ^ (32'h0101_0101 * {29'd0, addr[4:2]});
  endfunction

  function automatic logic [255:0] mk_line(input logic [31:0] seed);
    logic [255:0] l;
    for (int k = 0; k < 8; k++) l[k*32 +: 32] = seed ^ (32'h0101_0101 * k);
    return l;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
    fill_valid = 0; rn_valid = 0; inv_valid = 0; inv_all = 0;
  endtask

  task automatic set_fill(input logic p, input logic [31:0] a, input logic [7:0] rn,
                          input logic [31:0] seed);
    fill_valid = 1; fill_pipe = p; fill_addr = a; fill_reqno = rn; fill_line = mk_line(seed);
  endtask

  task automatic expect_q(input string req, input logic p, input logic [31:0] a,
                          input logic [7:0] rn, input logic eh, input logic [31:0] seed);
    q_pipe = p; q_addr = a; q_reqno = rn;
    #0.2;
    n_vec++;
    if (q_hit !== eh) begin
      n_bad++;
      $display("FAIL %s hit pipe=%0d addr=%h rn=%0d: got %b expected %b", req, p, a, rn, q_hit, eh);
    end
    if (eh) begin
      n_vec++;
      if (q_word !== exp_word(seed, a)) begin
        n_bad++;
        $display("FAIL %s word addr=%h: got %h expected %h", req, a, q_word, exp_word(seed, a));
      end
    end
  endtask

  task automatic t_reset();
    n_vec++;
    if (fill_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R2 fill_ready: got %b expected 1", fill_ready);
    end
    expect_q("R1", 0, 32'h0, 8'd0, 0, 0);
    expect_q("R1", 1, 32'h0, 8'd0, 0, 0);
  endtask

  task automatic t_fill_and_range();
    set_fill(0, 32'h1000_0044, 8'd5, 32'hA5A5_0000); tick();
    expect_q("R2_R10", 0, 32'h1000_0040, 8'd5, 1, 32'hA5A5_0000);
    expect_q("R4", 0, 32'h1000_005C, 8'd5, 1, 32'hA5A5_0000);
    expect_q("R4", 0, 32'h1000_0048, 8'd5, 1, 32'hA5A5_0000);
    expect_q("R3", 0, 32'h1000_0060, 8'd5, 0, 0);
    expect_q("R3", 0, 32'h1000_003C, 8'd5, 0, 0);
    expect_q("R3", 0, 32'h1000_0044, 8'd6, 0, 0);
    expect_q("R9", 1, 32'h1000_0044, 8'd5, 0, 0);
  endtask

  task automatic t_other_pipe();
    set_fill(1, 32'h2000_0010, 8'd9, 32'h1234_5678); tick();
    expect_q("R9", 1, 32'h2000_0014, 8'd9, 1, 32'h1234_5678);
    expect_q("R9", 0, 32'h1000_0050, 8'd5, 1, 32'hA5A5_0000);
  endtask

  task automatic t_reqno_write();
    rn_valid = 1; rn_pipe = 0; rn_reqno = 8'd7; tick();
    expect_q("R5", 0, 32'h1000_0040, 8'd5, 0, 0);
    expect_q("R5", 0, 32'h1000_0058, 8'd7, 1, 32'hA5A5_0000);
    expect_q("R9", 1, 32'h2000_0010, 8'd9, 1, 32'h1234_5678);
    set_fill(1, 32'h3000_0000, 8'd1, 32'h0F0F_F0F0);
    rn_valid = 1; rn_pipe = 1; rn_reqno = 8'd2; tick();
    expect_q("R5", 1, 32'h3000_0004, 8'd1, 0, 0);
    expect_q("R5", 1, 32'h3000_0004, 8'd2, 1, 32'h0F0F_F0F0);
  endtask

  task automatic t_inv_addr();
    set_fill(0, 32'h4000_0000, 8'd3, 32'hCAFE_0001); tick();
    set_fill(1, 32'h4000_0008, 8'd4, 32'hCAFE_0002); tick();
    inv_valid = 1; inv_addr = 32'h4000_0018; tick();
    expect_q("R6", 0, 32'h4000_0000, 8'd3, 0, 0);
    expect_q("R6", 1, 32'h4000_0008, 8'd4, 0, 0);
    set_fill(0, 32'h5000_0000, 8'd8, 32'hBEEF_0003); tick();
    inv_valid = 1; inv_addr = 32'h5000_0020; tick();
    expect_q("R6", 0, 32'h5000_001C, 8'd8, 1, 32'hBEEF_0003);
  endtask

  task automatic t_inv_all();
    set_fill(1, 32'h5100_0000, 8'd11, 32'h7777_0000); tick();
    inv_all = 1; tick();
    expect_q("R7", 0, 32'h5000_0000, 8'd8, 0, 0);
    expect_q("R7", 1, 32'h5100_0000, 8'd11, 0, 0);
  endtask

  task automatic t_fill_vs_inv();
    set_fill(1, 32'h6000_0000, 8'd1, 32'h1111_0000); tick();
    set_fill(0, 32'h6000_0000, 8'd2, 32'h2222_0000);
    inv_valid = 1; inv_addr = 32'h6000_0004; tick();
    expect_q("R8", 0, 32'h6000_000C, 8'd2, 1, 32'h2222_0000);
    expect_q("R8", 1, 32'h6000_0000, 8'd1, 0, 0);
    set_fill(1, 32'h6100_0020, 8'd3, 32'h3333_0000); tick();
    set_fill(0, 32'h6200_0000, 8'd4, 32'h4444_0000);
    inv_all = 1; tick();
    expect_q("R8", 0, 32'h6200_0010, 8'd4, 1, 32'h4444_0000);
    expect_q("R8", 1, 32'h6100_0020, 8'd3, 0, 0);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    rst_n = 0;
    fill_valid = 0; fill_pipe = 0; fill_addr = 0; fill_reqno = 0; fill_line = '0;
    rn_valid = 0; rn_pipe = 0; rn_reqno = 0;
    inv_valid = 0; inv_addr = 0; inv_all = 0;
    q_pipe = 0; q_addr = 0; q_reqno = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    t_reset();
    t_fill_and_range();
    t_other_pipe();
    t_reqno_write();
    t_inv_addr();
    t_inv_all();
    t_fill_vs_inv();
    done = 1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      report();
    end
  end
endmodule